// File: doc/BRIEF.md
# Power Converter Fault Supervisor

This block collects the digital results of the protection comparators of an offline LED driver controller and decides which power paths may run. It drives three enables: one for the main switch gate driver, one for the dimmer-compatibility path and one for the active clamp. It also reports a code naming the fault that is currently in charge. Each class of fault has its own way back to normal operation:

- Output overvoltage, primary overcurrent and open loop share a short automatic retry.
- Overpower in the dimmer-compatibility switch uses a much longer retry.
- Die overtemperature clears by hysteresis.
- Clamp overpower stays latched until power-on reset.

Retry delays are counted in ticks of a prescaled clock. A parameter sets the tick period, so the delays can be shortened for simulation. The clamp-active level is sampled on a second prescaled tick and run through a first-order averaging filter. When that average goes above one tenth of full scale, the clamp overpower latch sets.

Top module: `fs_supervisor`

## Requirements
- R1: Synchronous reset (`rst_i` high) leaves all three enables at 1 and `status_o` at 0 (no fault).
- R2: A high `ovp_i`, `ocp_i` or `olp_i` while the short-retry class is idle forces `gate_en_o` low from the next clock. `dimcomp_en_o` and `clamp_en_o` stay high.
- R3: A short-retry fault holds the gate off until the SHORT_TICKS-th retry tick after the trip; one retry tick occurs every TICK_DIV clocks. More short flags during the wait are ignored and do not extend it.
- R4: A high `sop_i` forces `gate_en_o` and `dimcomp_en_o` low from the next clock while `clamp_en_o` stays high. Both are released on the LONG_TICKS-th retry tick after the trip.
- R5: A high `temp_trip_i` turns the gate off from the next clock. The gate stays off while neither temperature flag is high, and returns the clock after `temp_clear_i` is high with `temp_trip_i` low.
- R6: On each sample tick (every SAMPLE_DIV clocks) the average A in 0..2^FRAC_W changes. If `clamp_act_i` is high, A becomes A + ((2^FRAC_W - A) >> AVG_SHIFT); otherwise A becomes A - (A >> AVG_SHIFT). A starts at 0 after reset. When the updated A exceeds floor(2^FRAC_W/10), the clamp fault latches.
- R7: A latched clamp fault drives all three enables low and `status_o` to 6. It ignores every other input and clears only on reset.
- R8: `status_o` gives the highest active fault. The codes are clamp overpower 6 > switch overpower 5 > overtemperature 4 > overvoltage 3 > overcurrent 2 > open loop 1, and none is 0. Simultaneous short flags are ranked the same way.
- R9: `gate_en_o` is high exactly when `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| ovp_i | input | 1 | Output overvoltage flag |
| ocp_i | input | 1 | Primary overcurrent flag |
| olp_i | input | 1 | Open-loop flag (sense never reached its floor) |
| sop_i | input | 1 | Dimmer-compatibility switch overpower flag |
| temp_trip_i | input | 1 | Die temperature above the trip point |
| temp_clear_i | input | 1 | Die temperature below the release point |
| clamp_act_i | input | 1 | Clamp conducting level |
| gate_en_o | output | 1 | Gate driver enable |
| dimcomp_en_o | output | 1 | Dimmer-compatibility path enable |
| clamp_en_o | output | 1 | Clamp enable |
| status_o | output | 3 | Code of highest-priority active fault |

## Verification
A retry counter stuck or off by one shows up as a gate that comes back a whole retry tick early or late. The bench measures this against a window of one tick period. A wrong priority merge or a wrong cause capture changes `status_o` on the clock after the flag. A drifting filter state shows up as a clamp latch that sets when it should not, or fails to set, during long periodic clamp patterns. Each pattern's outcome is worked out from the filter equation. A latch that leaks away would reopen the enables within a few clocks of the next flag or tick.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [2:0] {
        FS_NONE = 3'd0,
        FS_OLP  = 3'd1,
        FS_OCP  = 3'd2,
        FS_OVP  = 3'd3,
        FS_OTP  = 3'd4,
        FS_SOP  = 3'd5,
        FS_COP  = 3'd6
    } fs_code_e;

    typedef struct packed {
        logic gate;
        logic dimcomp;
        logic clamp;
    } fs_enables_t;

    // higher code value means higher priority
    function automatic fs_code_e fs_pick(input fs_code_e a, input fs_code_e b);
        return (b > a) ? b : a;
    endfunction

    function automatic fs_code_e fs_short_cause(input logic ovp, input logic ocp,
                                                input logic olp);
        if (ovp) return FS_OVP;
        if (ocp) return FS_OCP;
        if (olp) return FS_OLP;
        return FS_NONE;
    endfunction

    function automatic fs_enables_t fs_enables_for(input fs_code_e c);
        fs_enables_t e;
        e.gate    = (c == FS_NONE);
        e.dimcomp = (c != FS_SOP) && (c != FS_COP);
        e.clamp   = (c != FS_COP);
        return e;
    endfunction

    function automatic int fs_duty_limit(input int frac_w);
        return (1 << frac_w) / 10;
    endfunction

endpackage

// File: rtl/fs_prescaler.sv
module fs_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = 1'b1;
        end else begin : g_cnt
            logic [W-1:0] cnt;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cnt <= '0;
                end else if (cnt == W'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick_o = (cnt == W'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/fs_retry_timer.sv
module fs_retry_timer
    import fs_pkg::*;
#(
    parameter int N_TICKS = 1000
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     tick_i,
    input  logic     trip_i,
    input  fs_code_e cause_i,
    output logic     active_o,
    output fs_code_e cause_o
);
    localparam int CW = $clog2(N_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          active;
    fs_code_e      cause;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active <= 1'b0;
            cnt    <= '0;
            cause  <= FS_NONE;
        end else if (!active) begin
            if (trip_i) begin
                active <= 1'b1;
                cnt    <= '0;
                cause  <= cause_i;
            end
        end else if (tick_i) begin
            if (cnt == CW'(N_TICKS - 1)) begin
                active <= 1'b0;
                cnt    <= '0;
                cause  <= FS_NONE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign active_o = active;
    assign cause_o  = cause;
endmodule

// File: rtl/fs_clamp_avg.sv
module fs_clamp_avg
    import fs_pkg::*;
#(
    parameter int FRAC_W    = 12,
    parameter int AVG_SHIFT = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sample_i,
    input  logic clamp_act_i,
    output logic latched_o
);
    localparam int AW   = FRAC_W + 1;
    localparam int FULL = 1 << FRAC_W;
    localparam logic [AW-1:0] FULL_V = AW'(FULL);
    localparam logic [AW-1:0] LIMIT  = AW'(fs_duty_limit(FRAC_W));

    logic [AW-1:0] avg;
    logic [AW-1:0] avg_nxt;
    logic [AW-1:0] rise;
    logic [AW-1:0] fall;
    logic          latched;

    always_comb begin
        rise    = (FULL_V - avg) >> AVG_SHIFT;
        fall    = avg >> AVG_SHIFT;
        avg_nxt = clamp_act_i ? (avg + rise) : (avg - fall);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            avg     <= '0;
            latched <= 1'b0;
        end else if (sample_i && !latched) begin
            avg <= avg_nxt;
            if (avg_nxt > LIMIT) begin
                latched <= 1'b1;
            end
        end
    end

    assign latched_o = latched;
endmodule

// File: rtl/fs_supervisor.sv
module fs_supervisor
    import fs_pkg::*;
#(
    parameter int TICK_DIV    = 100000,
    parameter int SHORT_TICKS = 1000,
    parameter int LONG_TICKS  = 30000,
    parameter int SAMPLE_DIV  = 1000,
    parameter int FRAC_W      = 12,
    parameter int AVG_SHIFT   = 6
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ovp_i,
    input  logic       ocp_i,
    input  logic       olp_i,
    input  logic       sop_i,
    input  logic       temp_trip_i,
    input  logic       temp_clear_i,
    input  logic       clamp_act_i,
    output logic       gate_en_o,
    output logic       dimcomp_en_o,
    output logic       clamp_en_o,
    output logic [2:0] status_o
);
    logic        retry_tick;
    logic        sample_tick;
    logic        short_act;
    logic        long_act;
    fs_code_e    short_cause;
    fs_code_e    long_cause;
    logic        cop_latched;
    logic        hot;
    fs_code_e    status;
    fs_enables_t en;

    fs_prescaler #(.DIV(TICK_DIV)) u_retry_pre (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(retry_tick)
    );

    fs_prescaler #(.DIV(SAMPLE_DIV)) u_sample_pre (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(sample_tick)
    );

    fs_retry_timer #(.N_TICKS(SHORT_TICKS)) u_short (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (retry_tick),
        .trip_i  (ovp_i | ocp_i | olp_i),
        .cause_i (fs_short_cause(ovp_i, ocp_i, olp_i)),
        .active_o(short_act),
        .cause_o (short_cause)
    );

    fs_retry_timer #(.N_TICKS(LONG_TICKS)) u_long (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (retry_tick),
        .trip_i  (sop_i),
        .cause_i (FS_SOP),
        .active_o(long_act),
        .cause_o (long_cause)
    );

    fs_clamp_avg #(.FRAC_W(FRAC_W), .AVG_SHIFT(AVG_SHIFT)) u_clamp (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sample_i   (sample_tick),
        .clamp_act_i(clamp_act_i),
        .latched_o  (cop_latched)
    );

    // temperature hold with hysteresis: trip wins over clear
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hot <= 1'b0;
        end else if (temp_trip_i) begin
            hot <= 1'b1;
        end else if (temp_clear_i) begin
            hot <= 1'b0;
        end
    end

    always_comb begin
        status = FS_NONE;
        if (short_act)   status = fs_pick(status, short_cause);
        if (hot)         status = fs_pick(status, FS_OTP);
        if (long_act)    status = fs_pick(status, long_cause);
        if (cop_latched) status = fs_pick(status, FS_COP);
        en = fs_enables_for(status);
    end

    assign gate_en_o    = en.gate;
    assign dimcomp_en_o = en.dimcomp;
    assign clamp_en_o   = en.clamp;
    assign status_o     = status;
endmodule

// File: rtl/fs_supervisor_chk.sv
module fs_supervisor_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ovp_i,
    input logic       ocp_i,
    input logic       olp_i,
    input logic       sop_i,
    input logic       temp_trip_i,
    input logic       temp_clear_i,
    input logic       gate_en_o,
    input logic       dimcomp_en_o,
    input logic       clamp_en_o,
    input logic [2:0] status_o
);
    p_gate_vs_status_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o == (status_o == 3'd0));

    p_short_trip_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovp_i || ocp_i || olp_i) |=> !gate_en_o);

    p_sop_trip_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        sop_i |=> (!gate_en_o && !dimcomp_en_o));

    p_temp_trip_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        temp_trip_i |=> !gate_en_o);

    p_temp_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == 3'd4 && !temp_clear_i) |=> !gate_en_o);

    p_cop_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == 3'd6) |=> (status_o == 3'd6));

    p_cop_all_off_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !clamp_en_o |-> (!gate_en_o && !dimcomp_en_o && status_o == 3'd6));

    p_code_range_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o <= 3'd6);
endmodule

bind fs_supervisor fs_supervisor_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ovp_i       (ovp_i),
    .ocp_i       (ocp_i),
    .olp_i       (olp_i),
    .sop_i       (sop_i),
    .temp_trip_i (temp_trip_i),
    .temp_clear_i(temp_clear_i),
    .gate_en_o   (gate_en_o),
    .dimcomp_en_o(dimcomp_en_o),
    .clamp_en_o  (clamp_en_o),
    .status_o    (status_o)
);

// File: tb/fs_supervisor_tb_top.sv
module fs_supervisor_tb_top;
    localparam int TD     = 8;
    localparam int NS     = 5;
    localparam int NL     = 20;
    localparam int SD     = 4;
    localparam int FW     = 12;
    localparam int SH     = 4;
    localparam int FULL   = 1 << FW;
    localparam int LIMIT  = FULL / 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ovp = 0, ocp = 0, olp = 0, sop = 0, ttrip = 0, tclr = 0, cact = 0;
    logic gate, dimc, clen;
    logic [2:0] st;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fs_supervisor #(
        .TICK_DIV(TD), .SHORT_TICKS(NS), .LONG_TICKS(NL),
        .SAMPLE_DIV(SD), .FRAC_W(FW), .AVG_SHIFT(SH)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .ovp_i(ovp), .ocp_i(ocp), .olp_i(olp),
        .sop_i(sop), .temp_trip_i(ttrip), .temp_clear_i(tclr),
        .clamp_act_i(cact), .gate_en_o(gate), .dimcomp_en_o(dimc),
        .clamp_en_o(clen), .status_o(st)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {ovp, ocp, olp, sop, ttrip, tclr, cact} = '0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
    endtask

    function automatic int short_code(input int kind);
        return (kind == 0) ? 1 : (kind == 1) ? 2 : 3;
    endfunction

    // peak of the clamp average for a repeating pattern of 'highs' high
    // samples followed by period-highs low samples (R6 equation)
    function automatic int iir_peak(input int period, input int highs, input int n);
        int a = 0;
        int pk = 0;
        for (int i = 0; i < n; i++) begin
            if ((i % period) < highs) a = a + ((FULL - a) >>> SH);
            else                      a = a - (a >>> SH);
            if (a > pk) pk = a;
        end
        return pk;
    endfunction

    // short fault of given kind, with optional extra flag mid-wait
    task automatic short_case(input int kind, input bit extra);
        int exp_code = short_code(kind);
        ovp = (kind == 2); ocp = (kind == 1); olp = (kind == 0);
        @(negedge clk);
        ovp = 0; ocp = 0; olp = 0;
        chk(!gate, "R2 gate off", gate, 0);
        chk(dimc && clen, "R2 others on", {dimc, clen}, 3);
        chk(int'(st) == exp_code, "R8 short code", st, exp_code);
        wait_n(TD);
        if (extra) begin
            ovp = 1'b1;
            @(negedge clk);
            ovp = 1'b0;
            wait_n((NS - 1) * TD - TD - 2);
        end else begin
            wait_n((NS - 1) * TD - TD - 1);
        end
        chk(!gate, "R3 still waiting", gate, 0);
        wait_n(TD + 2);
        chk(gate, "R3 released", gate, 1);
        chk(int'(st) == 0, "R9 status clear", st, 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        do_reset();
        chk(gate && dimc && clen, "R1 enables", {gate, dimc, clen}, 7);
        chk(st == 3'd0, "R1 status", st, 0);

        // directed short faults of each kind
        for (int k = 0; k < 3; k++) short_case(k, 1'b0);
        short_case(2, 1'b1);

        // constrained random short faults
        for (int i = 0; i < 16; i++) begin
            wait_n(1 + ($urandom % 7));
            short_case($urandom % 3, $urandom % 2);
        end

        // simultaneous short flags: priority R8
        ovp = 1; ocp = 1; olp = 1;
        @(negedge clk);
        ovp = 0; ocp = 0; olp = 0;
        chk(st == 3'd3, "R8 ovp over ocp/olp", st, 3);
        wait_n(NS * TD + 2);
        ocp = 1; olp = 1;
        @(negedge clk);
        ocp = 0; olp = 0;
        chk(st == 3'd2, "R8 ocp over olp", st, 2);
        wait_n(NS * TD + 2);

        // switch overpower with long retry, overlapping short fault
        sop = 1; ovp = 1;
        @(negedge clk);
        sop = 0; ovp = 0;
        chk(!gate && !dimc && clen, "R4 sop enables", {gate, dimc, clen}, 1);
        chk(st == 3'd5, "R8 sop over ovp", st, 5);
        wait_n(NS * TD + 2);
        chk(st == 3'd5 && !dimc, "R4 held after short", st, 5);
        wait_n((NL - 1) * TD - NS * TD - 3);
        chk(!dimc, "R4 still waiting", dimc, 0);
        wait_n(TD + 2);
        chk(dimc && gate && st == 3'd0, "R4 released", st, 0);

        // temperature hysteresis
        ttrip = 1;
        @(negedge clk);
        ttrip = 0;
        chk(!gate && st == 3'd4, "R5 trip", st, 4);
        wait_n(50);
        chk(!gate && st == 3'd4, "R5 hold between points", st, 4);
        ttrip = 1; tclr = 1;
        @(negedge clk);
        ttrip = 0;
        chk(st == 3'd4, "R5 trip beats clear", st, 4);
        @(negedge clk);
        tclr = 0;
        chk(gate && st == 3'd0, "R5 release", st, 0);

        // clamp average: steady high trips after two samples from zero
        do_reset();
        cact = 1;
        @(negedge clk);
        chk(clen && st == 3'd0, "R6 no trip on first sample", st, 0);
        wait_n(2 * SD + 1);
        cact = 0;
        chk(!clen && !gate && !dimc && st == 3'd6, "R7 latched all off", st, 6);
        sop = 1; ttrip = 1; tclr = 1;
        @(negedge clk);
        sop = 0; ttrip = 0;
        wait_n(NL * TD + 4);
        tclr = 0;
        chk(st == 3'd6 && !clen, "R7 sticky", st, 6);
        do_reset();
        chk(clen && gate && st == 3'd0, "R7 cleared by reset", st, 0);

        // periodic clamp patterns judged by the filter equation
        for (int p = 0; p < 3; p++) begin
            int per = (p == 0) ? 32 : (p == 1) ? 12 : 2;
            int reps = 480 / per;
            bit exp_trip = iir_peak(per, 1, reps * per) > LIMIT;
            do_reset();
            for (int r = 0; r < reps; r++) begin
                cact = 1; wait_n(SD);
                cact = 0; wait_n((per - 1) * SD);
            end
            wait_n(2);
            chk((st == 3'd6) == exp_trip, "R6 duty pattern", st, exp_trip ? 6 : 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule